// File: doc/BRIEF.md
# Guess-Carry Split Adder

This block adds two unsigned operands of `WIDTH` bits plus a carry-in, using one adder for the low half of the word and one for the high half. When a request is accepted, both halves are added in the same cycle. The low half uses the real carry-in. The high half uses a carry-in guessed to be zero. If the low half does not produce a carry, the guess was right and the result is registered at once. If it does produce a carry, the high half is added again in the next cycle with a carry of one. That second pass reuses the same adder, fed from operand copies captured at acceptance.

Latency is therefore one or two cycles. A single-cycle `done` pulse marks the cycle in which `sum` and `cout` hold the new result. A `miss` flag registered with it tells whether the repair pass was needed. A request asserted while a repair is under way is dropped. A new request may be asserted in every cycle in which the block is idle.

Top module: `guess_carry_adder`

## Requirements
- R1: While `rst` is high at a rising edge, `sum`, `cout`, `done` and `miss` are cleared to 0. They stay 0 until a request completes.
- R2: If `start` is sampled high while idle and the low half produces no carry, then one edge later `done`=1 and `miss`=0. At that point {`cout`,`sum`} equals `a`+`b`+`cin` as sampled with `start`. The low half is bits [WIDTH/2-1:0], and its carry is bit WIDTH/2 of low(`a`)+low(`b`)+`cin`.
- R3: If the low half does produce a carry, then `done` is 0 one edge after `start`. Two edges after `start`, `done`=1 and `miss`=1, and {`cout`,`sum`} equals `a`+`b`+`cin` as sampled with `start`.
- R4: `done` is high for exactly one cycle per accepted request. It is never high except at the completion edge of a request.
- R5: Changes to `a`, `b` or `cin` after the accepting edge have no effect on the result of a request that is being repaired.
- R6: `start` asserted during the repair cycle is ignored. It produces no later `done`, and the result of the ongoing request is unchanged.
- R7: `sum` and `cout` keep their value in every cycle in which `done` is 0.
- R8: The result is correct when the carry from the low half has to pass through an all-ones high half, with `cout`=1 at full-width overflow. Example: `a`=16'hFFFF, `b`=0, `cin`=1 gives `sum`=0, `cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, accepted only while idle |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum, held between completions |
| cout | output | 1 | Registered carry out of the top bit |
| done | output | 1 | One-cycle pulse: `sum`/`cout` are new this cycle |
| miss | output | 1 | Valid with `done`: 1 if the carry guess was wrong |

## Verification
A request whose low half carries nothing must complete at the first rising edge after the one that samples `start`. A request whose low half carries must show `done` low after that first edge and complete at the second edge. The bench drives inputs on falling edges and reads outputs on the following falling edges. Each check therefore lands half a cycle after the edge where the result is due. It also confirms that `done` is low at the falling edge after the one where the result is read. Operands are chosen on both sides of the low-half carry boundary. They include a carry that ripples through an all-ones upper half and a request issued while a repair is in progress.

// File: rtl/gca_pkg.sv
`timescale 1ns/1ps
package gca_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FIX  = 1'b1
  } gca_state_e;
endpackage

// File: rtl/gca_half_add.sv
`timescale 1ns/1ps
// Plain ripple-style half-word adder with carry in and out.
module gca_half_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] tot;
  always_comb begin
    tot = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    s   = tot[W-1:0];
    co  = tot[W];
  end
endmodule

// File: rtl/gca_ctrl.sv
`timescale 1ns/1ps
// Accept / repair sequencer.
module gca_ctrl
  import gca_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic lo_co,
  output logic accept,
  output logic fix,
  output logic complete
);
  gca_state_e st_q;

  always_comb begin
    accept   = start && (st_q == ST_IDLE);
    fix      = (st_q == ST_FIX);
    complete = (accept && !lo_co) || fix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else if (fix) begin
      st_q <= ST_IDLE;
    end else if (accept && lo_co) begin
      st_q <= ST_FIX;
    end
  end
endmodule

// File: rtl/guess_carry_adder.sv
`timescale 1ns/1ps
module guess_carry_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             done,
  output logic             miss
);
  localparam int LO_W = WIDTH / 2;
  localparam int HI_W = WIDTH - LO_W;

  logic            accept, fix, complete;
  logic [LO_W-1:0] lo_s;
  logic            lo_co;
  logic [HI_W-1:0] hi_x, hi_y, hi_s;
  logic            hi_ci, hi_co;
  logic [HI_W-1:0] hi_a_q, hi_b_q;
  logic [LO_W-1:0] lo_s_q;
  logic            busy_w;

  gca_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lo_co    (lo_co),
    .accept   (accept),
    .fix      (fix),
    .complete (complete)
  );

  // Low half: always the live operands with the true carry-in.
  gca_half_add #(.W(LO_W)) u_lo (
    .x  (a[LO_W-1:0]),
    .y  (b[LO_W-1:0]),
    .ci (cin),
    .s  (lo_s),
    .co (lo_co)
  );

  // Single high-half adder: guessed carry 0 on accept, carry 1 on repair.
  always_comb begin
    hi_x  = fix ? hi_a_q : a[WIDTH-1:LO_W];
    hi_y  = fix ? hi_b_q : b[WIDTH-1:LO_W];
    hi_ci = fix;
  end

  gca_half_add #(.W(HI_W)) u_hi (
    .x  (hi_x),
    .y  (hi_y),
    .ci (hi_ci),
    .s  (hi_s),
    .co (hi_co)
  );

  assign busy_w = fix;

  // Operand capture for the repair pass.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_a_q <= '0;
      hi_b_q <= '0;
      lo_s_q <= '0;
    end else if (accept) begin
      hi_a_q <= a[WIDTH-1:LO_W];
      hi_b_q <= b[WIDTH-1:LO_W];
      lo_s_q <= lo_s;
    end
  end

  // Registered results.
  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
      done <= 1'b0;
      miss <= 1'b0;
    end else begin
      done <= complete;
      if (complete) begin
        sum  <= {hi_s, (fix ? lo_s_q : lo_s)};
        cout <= hi_co;
        miss <= fix;
      end
    end
  end
endmodule

// File: rtl/gca_chk.sv
`timescale 1ns/1ps
module gca_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic             done,
  input logic             miss,
  input logic             busy
);
  localparam int LO_W = WIDTH / 2;

  logic [LO_W:0]  lo_tot;
  logic [WIDTH:0] full_tot;
  logic           lo_carry;
  always_comb begin
    lo_tot   = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
    full_tot = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    lo_carry = lo_tot[LO_W];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!done && !miss && !cout && sum == '0));

  // R2
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !lo_carry) |=> (done && !miss && {cout, sum} == $past(full_tot)));

  // R3
  miss_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && lo_carry) |=> (!done ##1 (done && miss && {cout, sum} == $past(full_tot, 2))));

  // R4
  done_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(rst)) |-> ($past(busy) || ($past(start) && !$past(busy))));

  // R6
  repair_once_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(sum) && $stable(cout)));
endmodule

bind guess_carry_adder gca_chk #(.WIDTH(WIDTH)) u_gca_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .done  (done),
  .miss  (miss),
  .busy  (busy_w)
);

// File: tb/test_guess_carry_adder.sv
`timescale 1ns/1ps
module test_guess_carry_adder;
  localparam int W = 16;
  localparam int H = W / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cin = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] sum;
  logic         cout, done, miss;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  guess_carry_adder #(.WIDTH(W)) i_guess_carry_adder (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .cin(cin),
    .sum(sum), .cout(cout), .done(done), .miss(miss)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic lo_carry(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [H:0] t;
    t = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, c};
    return t[H];
  endfunction

  function automatic logic [W:0] full(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 miss after reset", miss, 0);
    chk("R1 cout after reset", cout, 0);
    chk("R1 sum after reset", sum, 0);
  endtask

  // One request; latency chosen from the low-half carry.
  task automatic t_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
    logic [W:0] ex;
    ex = full(x, y, c);
    @(negedge clk);
    a = x; b = y; cin = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lo_carry(x, y, c)) begin
      chk({"R3 no done at first edge ", tag}, done, 0);
      @(negedge clk);
      chk({"R3 done at second edge ", tag}, done, 1);
      chk({"R3 miss flag ", tag}, miss, 1);
      chk({"R3 result ", tag}, {cout, sum}, ex);
    end else begin
      chk({"R2 done at first edge ", tag}, done, 1);
      chk({"R2 miss flag ", tag}, miss, 0);
      chk({"R2 result ", tag}, {cout, sum}, ex);
    end
    @(negedge clk);
    chk({"R4 done single pulse ", tag}, done, 0);
  endtask

  // Two hits on consecutive cycles.
  task automatic t_back_to_back();
    @(negedge clk);
    a = 16'h1111; b = 16'h2222; cin = 1'b0; start = 1'b1;
    @(negedge clk);
    chk("R2 back-to-back first done", done, 1);
    chk("R2 back-to-back first result", {cout, sum}, 17'h03333);
    a = 16'h7001; b = 16'h9002; cin = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 back-to-back second done", done, 1);
    chk("R2 back-to-back second result", {cout, sum}, 17'h10004);
    @(negedge clk);
    chk("R4 back-to-back done drops", done, 0);
  endtask

  // Miss, then new operands and a start during the repair cycle.
  task automatic t_repair_disturb();
    @(negedge clk);
    a = 16'h12F0; b = 16'h3410; cin = 1'b0; start = 1'b1;
    @(negedge clk);
    chk("R3 disturb no early done", done, 0);
    a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 done after repair", done, 1);
    chk("R5 result keeps captured operands", {cout, sum}, 17'h04700);
    @(negedge clk);
    chk("R6 ignored start gives no done", done, 0);
    chk("R6 result unchanged", {cout, sum}, 17'h04700);
    @(negedge clk);
    chk("R6 still no done", done, 0);
  endtask

  task automatic t_hold();
    t_op(16'h0A0B, 16'h0102, 1'b0, "hold seed");
    for (int i = 0; i < 3; i++) begin
      a = 16'hFFFF - 16'(i); b = 16'(i * 7); cin = i[0];
      @(negedge clk);
      chk("R7 sum held", sum, 16'h0B0D);
      chk("R7 cout held", cout, 0);
      chk("R7 no done without start", done, 0);
    end
  endtask

  initial begin
    t_reset();
    t_op(16'h1234, 16'h0101, 1'b0, "plain hit");
    t_op(16'h00FF, 16'h0000, 1'b0, "low all ones no carry");
    t_op(16'h00FF, 16'h0000, 1'b1, "carry from cin");
    t_op(16'h0080, 16'h0080, 1'b0, "carry from operands");
    t_op(16'hFFFF, 16'h0000, 1'b1, "R8 ripple through high half");
    t_op(16'hFF00, 16'h0100, 1'b0, "R8 overflow on hit");
    t_op(16'hFFFF, 16'hFFFF, 1'b1, "R8 max operands");
    t_back_to_back();
    t_repair_disturb();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule